// File: doc/BRIEF.md
# Gearing Update Strobe Generator

This block creates the handoff strobes that let an I/O serializer or deserializer move a word between a fast bit clock and a slow word clock. A circular one-hot ring of length N (the gearing ratio: 1, 2 or 4) runs on a fast clock. That clock is chosen from either the input-side or the output-side fast clock. On every N-th fast rising edge the ring produces a one-cycle strobe for rising-edge capture. A falling-edge register then re-times the same strobe half a fast cycle later for falling-edge capture. A static select routes one of the two strobes out as a general update signal.

The ring is loaded from a reset taken either from an edge-wide reset or from a local reset, each with its own optional inversion. That reset asserts asynchronously and is released through a short synchronizer on the selected fast clock. All configuration inputs are static and may only change while the selected reset is asserted. When the gearing function is disabled, both strobes stay low.

Top module: `gear_strobe_gen`

## Requirements
- R1: While the selected reset is active, the rising-edge strobe is low after one selected fast rising edge, and the falling-edge strobe and the update output are low after the following falling edge.
- R2: The effective reset is the edge reset XOR its invert bit when the source select is 0, or the local reset XOR its invert bit when the source select is 1; activity on the unselected source has no effect on the strobes.
- R3: After the effective reset is released, the rising-edge strobe first goes high after fast rising edge N+2 (two synchronizer stages, then N ring steps) and then again after every N further edges.
- R4: At ratio 1 the rising-edge strobe stays high continuously from fast edge 3 after release.
- R5: With the gearing enable low, both strobes and the update output stay low.
- R6: The falling-edge strobe takes the value of the rising-edge strobe on each falling edge of the fast clock, lagging it by half a fast cycle.
- R7: For ratios above 1, each rising-edge strobe pulse lasts exactly one fast cycle.
- R8: The update output equals the rising-edge strobe when the output select is 0 and the falling-edge strobe when it is 1.
- R9: Clock select 0 runs the block on the input-side fast clock and 1 on the output-side fast clock; the unselected clock is not needed.
- R10: The 2-bit ratio code maps 0 to ratio 1, 1 to ratio 2, 2 to ratio 4, and 3 is clamped to ratio 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in_fast | input | 1 | Input-side fast clock |
| clk_out_fast | input | 1 | Output-side fast clock |
| cfg_clk_sel | input | 1 | Fast clock select: 0 input side, 1 output side |
| edge_rst | input | 1 | Edge-wide reset source |
| local_rst | input | 1 | Local reset source |
| cfg_rst_sel | input | 1 | Reset source select: 0 edge, 1 local |
| cfg_inv_edge | input | 1 | Invert edge reset before use |
| cfg_inv_local | input | 1 | Invert local reset before use |
| cfg_shift_en | input | 1 | Gearing enable; low keeps strobes low |
| cfg_ratio | input | 2 | Ratio code (0:1, 1:2, 2:4, 3:4) |
| cfg_upd_sel | input | 1 | Update output select: 0 rising, 1 falling strobe |
| upd_pos | output | 1 | Rising-edge handoff strobe |
| upd_neg | output | 1 | Falling-edge handoff strobe |
| upd_out | output | 1 | Selected update strobe |

## Verification
The bench builds the block with its defaults: a maximum ratio of 4, which gives a 2-bit ratio code, and two synchronizer stages. At that size the bench can sweep every ratio code, including the clamped code, with every combination of enable, clock select, output select, reset source and both inversion bits. For each combination it checks the exact release latency and pulse spacing edge by edge. The unselected clock is held stopped and the unselected reset is pulsed during each run, so a wrong clock or reset path shows up as a wrong strobe.

// File: rtl/gear_strobe_pkg.sv
package gear_strobe_pkg;

  // Ring length for a ratio code: a power of two, clamped to the maximum.
  function automatic int gs_len(input int code, input int max_ratio);
    int l;
    if (code >= 30) l = max_ratio;
    else l = 1 << code;
    if (l > max_ratio) l = max_ratio;
    return l;
  endfunction

endpackage

// File: rtl/gs_rst_ctrl.sv
module gs_rst_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic edge_rst,
  input  logic local_rst,
  input  logic rst_sel,
  input  logic inv_edge,
  input  logic inv_local,
  output logic rst_sync
);
  logic rst_raw;
  logic [SYNC_STAGES-1:0] sr_q;

  assign rst_raw = rst_sel ? (local_rst ^ inv_local) : (edge_rst ^ inv_edge);

  // Asynchronous assertion, release timed to the fast clock.
  always_ff @(posedge clk or posedge rst_raw) begin
    if (rst_raw) sr_q <= '1;
    else         sr_q <= {sr_q[SYNC_STAGES-2:0], 1'b0};
  end

  assign rst_sync = sr_q[SYNC_STAGES-1];
endmodule

// File: rtl/gs_ring.sv
module gs_ring
  import gear_strobe_pkg::*;
#(
  parameter int MAX_RATIO = 4,
  localparam int CODE_W = $clog2($clog2(MAX_RATIO) + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic [CODE_W-1:0]    ratio_code,
  output logic [MAX_RATIO-1:0] ring_q,
  output logic                 pos_q
);
  int len;
  logic [MAX_RATIO-1:0] nxt;
  logic [MAX_RATIO-1:0] pre;

  always_comb len = gs_len(int'(ratio_code), MAX_RATIO);

  for (genvar i = 0; i < MAX_RATIO; i++) begin : g_bit
    logic upper;
    if (i == MAX_RATIO - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = ring_q[i+1];
    end
    assign nxt[i] = (i == len - 1) ? ring_q[0] : ((i < len - 1) ? upper : 1'b0);
    assign pre[i] = (i == len - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= pre;
      pos_q  <= 1'b0;
    end else begin
      ring_q <= nxt;
      pos_q  <= shift_en & ring_q[0];
    end
  end
endmodule

// File: rtl/gs_neg_stage.sv
module gs_neg_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/gear_strobe_gen.sv
module gear_strobe_gen #(
  parameter int MAX_RATIO   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W = $clog2($clog2(MAX_RATIO) + 1)
) (
  input  logic              clk_in_fast,
  input  logic              clk_out_fast,
  input  logic              cfg_clk_sel,
  input  logic              edge_rst,
  input  logic              local_rst,
  input  logic              cfg_rst_sel,
  input  logic              cfg_inv_edge,
  input  logic              cfg_inv_local,
  input  logic              cfg_shift_en,
  input  logic [CODE_W-1:0] cfg_ratio,
  input  logic              cfg_upd_sel,
  output logic              upd_pos,
  output logic              upd_neg,
  output logic              upd_out
);
  logic fclk;
  logic rst_sync;
  logic pos_q;
  logic neg_q;
  logic [MAX_RATIO-1:0] ring_q;

  // Static select; changes only while in reset.
  assign fclk = cfg_clk_sel ? clk_out_fast : clk_in_fast;

  gs_rst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk(fclk), .edge_rst(edge_rst), .local_rst(local_rst), .rst_sel(cfg_rst_sel),
    .inv_edge(cfg_inv_edge), .inv_local(cfg_inv_local), .rst_sync(rst_sync)
  );

  gs_ring #(.MAX_RATIO(MAX_RATIO)) u_ring (
    .clk(fclk), .rst(rst_sync), .shift_en(cfg_shift_en), .ratio_code(cfg_ratio),
    .ring_q(ring_q), .pos_q(pos_q)
  );

  gs_neg_stage u_neg (.clk(fclk), .rst(rst_sync), .d(pos_q), .q(neg_q));

  assign upd_pos = pos_q;
  assign upd_neg = neg_q;
  assign upd_out = cfg_upd_sel ? neg_q : pos_q;
endmodule

// File: rtl/gs_strobe_checker.sv
module gs_strobe_checker #(
  parameter int MAX_RATIO = 4,
  localparam int CODE_W = $clog2($clog2(MAX_RATIO) + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 shift_en,
  input logic [CODE_W-1:0]    ratio_code,
  input logic [MAX_RATIO-1:0] ring,
  input logic                 upd_pos,
  input logic                 upd_neg
);
  // R3: the ring always carries exactly one token
  a_r3_single_token: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == 1);

  // R5: disabled gearing keeps the rising strobe low
  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> !upd_pos);

  // R4: ratio 1 holds the strobe high once running
  a_r4_unit_high: assert property (@(posedge clk) disable iff (rst)
    (shift_en && ratio_code == '0 && !$past(rst)) |-> upd_pos);

  // R7: pulses last one fast cycle for ratios above 1
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (upd_pos && ratio_code != '0) |=> !upd_pos);

  // R6: falling stage has caught up with the rising strobe by each rising edge
  a_r6_neg_follows: assert property (@(posedge clk) disable iff (rst)
    upd_neg == upd_pos);
endmodule

bind gear_strobe_gen gs_strobe_checker #(.MAX_RATIO(MAX_RATIO)) u_gs_chk (
  .clk(fclk), .rst(rst_sync), .shift_en(cfg_shift_en), .ratio_code(cfg_ratio),
  .ring(ring_q), .upd_pos(pos_q), .upd_neg(neg_q)
);

// File: tb/test_gear_strobe_gen.sv
module test_gear_strobe_gen;
  logic clk_i = 1'b0, clk_o = 1'b0;
  logic en_i = 1'b1, en_o = 1'b0;
  logic cfg_clk_sel = 1'b0, cfg_rst_sel = 1'b0;
  logic cfg_inv_edge = 1'b0, cfg_inv_local = 1'b0;
  logic cfg_shift_en = 1'b1, cfg_upd_sel = 1'b0;
  logic [1:0] cfg_ratio = 2'd0;
  logic edge_rst = 1'b1, local_rst = 1'b0;
  logic upd_pos, upd_neg, upd_out;
  int n_checks = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = en_i ? ~clk_i : 1'b0;
  always #5 clk_o = en_o ? ~clk_o : 1'b0;

  gear_strobe_gen i_gear_strobe_gen (
    .clk_in_fast(clk_i), .clk_out_fast(clk_o), .cfg_clk_sel(cfg_clk_sel),
    .edge_rst(edge_rst), .local_rst(local_rst), .cfg_rst_sel(cfg_rst_sel),
    .cfg_inv_edge(cfg_inv_edge), .cfg_inv_local(cfg_inv_local),
    .cfg_shift_en(cfg_shift_en), .cfg_ratio(cfg_ratio), .cfg_upd_sel(cfg_upd_sel),
    .upd_pos(upd_pos), .upd_neg(upd_neg), .upd_out(upd_out)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  // Drive a reset source to its active (1) or idle (0) level under current polarity.
  task automatic set_src(input bit which, input bit active);
    if (which == 1'b0) edge_rst = active ^ cfg_inv_edge;
    else               local_rst = active ^ cfg_inv_local;
  endtask

  task automatic tick_pos();
    if (cfg_clk_sel) @(posedge clk_o); else @(posedge clk_i);
    #1;
  endtask

  task automatic tick_neg();
    if (cfg_clk_sel) @(negedge clk_o); else @(negedge clk_i);
    #1;
  endtask

  task automatic run_cfg(input int code, input bit sh, input bit cs, input bit us,
                         input bit rs, input bit ie, input bit il);
    int n;
    bit exp_p, prev_p;
    string tag;
    set_src(cfg_rst_sel, 1'b1);
    cfg_ratio = code[1:0]; cfg_shift_en = sh; cfg_clk_sel = cs; cfg_upd_sel = us;
    cfg_rst_sel = rs; cfg_inv_edge = ie; cfg_inv_local = il;
    en_i = !cs; en_o = cs;           // R9: unselected clock held stopped
    set_src(rs, 1'b1);
    set_src(!rs, 1'b0);
    repeat (3) tick_pos();
    chk(upd_pos, 1'b0, "R1 upd_pos in reset");
    tick_neg();
    chk(upd_neg, 1'b0, "R1 upd_neg in reset");
    chk(upd_out, 1'b0, "R1 upd_out in reset");
    set_src(rs, 1'b0);
    n = (code == 0) ? 1 : (code == 1) ? 2 : 4;   // R10 mapping
    tag = !sh ? "R5" : (n == 1) ? "R4" : (code == 3) ? "R10" : "R3";
    prev_p = 1'b0;
    for (int k = 1; k <= 3 * n + 3; k++) begin
      tick_pos();
      exp_p = sh && (k >= n + 2) && (((k - n - 2) % n) == 0);
      // R2 (other source pulsed), R7 (single-cycle pulses), R9 (clock path)
      chk(upd_pos, exp_p, $sformatf("%s R2 R7 R9 upd_pos N=%0d k=%0d cs=%0b rs=%0b",
                                    tag, n, k, cs, rs));
      chk(upd_out, us ? prev_p : exp_p, $sformatf("R8 upd_out sel=%0b N=%0d k=%0d", us, n, k));
      if (k == 2) set_src(!rs, 1'b1);
      if (k == 4) set_src(!rs, 1'b0);
      tick_neg();
      chk(upd_neg, exp_p, $sformatf("R6 upd_neg N=%0d k=%0d", n, k));
      prev_p = exp_p;
    end
  endtask

  initial begin
    for (int code = 0; code < 4; code++)
      for (int sh = 0; sh < 2; sh++)
        for (int cs = 0; cs < 2; cs++)
          for (int us = 0; us < 2; us++)
            for (int rs = 0; rs < 2; rs++)
              for (int inv = 0; inv < 4; inv++)
                run_cfg(code, sh[0], cs[0], us[0], rs[0], inv[0], inv[1]);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule